// File: doc/BRIEF.md
# Interrupt Acceptance and Return Sequencer

This block sits on the CPU side of an interrupt system. It watches one arbitrated request (a valid flag, a 2-bit level and a vector number). It decides whether the request may interrupt the code that is running. If it may, the block saves the return context to a stack in memory, fetches the handler address and hands the CPU a new program counter and program status word. A separate return request reverses the process: the block pops the saved status and program counter and hands them back.

The decision uses two fields of the program status word. One is a global enable bit. The other is a 2-bit current level, where a smaller number means a higher priority. A request wins only if its level is strictly below the current level, and entry writes the accepted level into that field. A running handler can therefore be preempted only by something of strictly higher priority. Memory is reached through a plain synchronous port with byte addresses and 16-bit words; read data arrives one cycle after the request. The block keeps its own stack pointer, and the CPU applies the new PC and PS on single-cycle load strobes.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset `busy`, `mem_req`, `pc_load`, `ps_load` and `wake` are 0, and the internal stack pointer holds `SP_INIT` (0x0200 by default).
- R2: In an idle cycle a request is accepted only if `irq_valid` is 1, the enable bit PS[6] is 1 and `irq_level` is numerically less than the current level PS[5:4]. A request that fails the test causes no memory access and leaves `busy` at 0.
- R3: Entry writes the return PC at SP-2 in the cycle after acceptance, then writes the PS at SP-4 in the next cycle, so SP drops by 4 in total.
- R4: The cycle after the PS write issues a read at `VEC_BASE` + 2 × vector (`VEC_BASE` is 0x0040 by default). The read data is taken one cycle later.
- R5: One cycle after the vector data arrives, `pc_load` and `ps_load` pulse together for one cycle. `pc_value` is the vector word, and `ps_value` is the saved PS with bits [5:4] replaced by the accepted level and all other bits unchanged.
- R6: `wake` pulses for exactly one cycle, the cycle after acceptance (the cycle of the PC write).
- R7: `busy` is 1 in every cycle of an entry or return sequence. Requests are not sampled while busy. In the first idle cycle afterwards, the request is evaluated against the PC and PS being loaded in that same cycle, and those are also the values pushed.
- R8: A `reti_req` pulse in an idle cycle reads PS from SP and then PC from SP+2, raising SP by 4. The block then pulses `pc_load` and `ps_load` with the popped values. If `reti_req` and an acceptable request arrive in the same idle cycle, the return is started first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_valid | input | 1 | Arbitrated request present |
| irq_level | input | 2 | Level of the request, 0 is highest priority |
| irq_vector | input | 3 | Vector number of the request |
| reti_req | input | 1 | Return-from-interrupt pulse |
| cur_pc | input | 16 | Address of the next instruction to run |
| cur_ps | input | 16 | Current program status word |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Write when 1, read when 0 |
| mem_addr | output | 16 | Byte address of the 16-bit word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid one cycle after a read |
| pc_load | output | 1 | Load `pc_value` into the PC |
| pc_value | output | 16 | New program counter |
| ps_load | output | 1 | Load `ps_value` into the PS |
| ps_value | output | 16 | New program status word |
| busy | output | 1 | A sequence is in progress |
| wake | output | 1 | Leave-standby pulse on acceptance |

## Verification
The hardest case is a higher-priority request that is already waiting when an entry finishes. That request must be judged against the PS that is only being loaded in the same cycle, and it must push the handler address that is also only being loaded then. The bench reaches this case by replacing a level-1 request with a level-0 request while the first entry is still busy. A bench CPU model applies the loads one edge late. The second entry therefore has to push the first handler's address and the raised level, and it then has to stop at the level-0 request it has just adopted. The two nested returns then verify that both frames come back in reverse order.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_PUSH_PC, S_PUSH_PS, S_FETCH_VEC, S_JUMP,
    S_POP_PS, S_POP_PC, S_RESTORE
  } seq_state_t;
endpackage

// File: rtl/irq_admit.sv
module irq_admit #(
  parameter int LVL_W = 2
) (
  input  logic             irq_valid,
  input  logic [LVL_W-1:0] irq_level,
  input  logic             ien,
  input  logic [LVL_W-1:0] cur_lvl,
  output logic             take
);
  // strictly higher priority (smaller number) and globally enabled
  always_comb take = irq_valid && ien && (irq_level < cur_lvl);
endmodule

// File: rtl/irq_sp_reg.sv
module irq_sp_reg #(
  parameter int          ADDR_W  = 16,
  parameter logic [15:0] SP_INIT = 16'h0200,
  parameter int          STEP    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dec,
  input  logic              inc,
  output logic [ADDR_W-1:0] sp,
  output logic [ADDR_W-1:0] sp_dn
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

  always_comb sp_dn = sp - STEP_V;

  always_ff @(posedge clk) begin
    if (rst)      sp <= ADDR_W'(SP_INIT);
    else if (dec) sp <= sp_dn;
    else if (inc) sp <= sp + STEP_V;
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 16,
  parameter int          LVL_W    = 2,
  parameter int          VEC_W    = 3,
  parameter int          IL_LSB   = 4,
  parameter int          IEN_BIT  = 6,
  parameter logic [15:0] SP_INIT  = 16'h0200,
  parameter logic [15:0] VEC_BASE = 16'h0040
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq_valid,
  input  logic [LVL_W-1:0]  irq_level,
  input  logic [VEC_W-1:0]  irq_vector,
  input  logic              reti_req,
  input  logic [DATA_W-1:0] cur_pc,
  input  logic [DATA_W-1:0] cur_ps,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              pc_load,
  output logic [DATA_W-1:0] pc_value,
  output logic              ps_load,
  output logic [DATA_W-1:0] ps_value,
  output logic              busy,
  output logic              wake
);
  localparam int WORD_BYTES = DATA_W / 8;

  seq_state_t        state;
  logic [DATA_W-1:0] eff_pc, eff_ps, ps_hold, ps_entry;
  logic [LVL_W-1:0]  lvl_hold;
  logic [VEC_W-1:0]  vec_hold;
  logic [ADDR_W-1:0] sp, sp_dn, vec_addr;
  logic              in_idle, take, start_irq, start_ret, sp_dec, sp_inc;

  // forward loads issued in this very cycle so that re-evaluation sees them
  always_comb begin
    eff_pc = pc_load ? pc_value : cur_pc;
    eff_ps = ps_load ? ps_value : cur_ps;
  end

  irq_admit #(.LVL_W(LVL_W)) u_admit (
    .irq_valid (irq_valid),
    .irq_level (irq_level),
    .ien       (eff_ps[IEN_BIT]),
    .cur_lvl   (eff_ps[IL_LSB +: LVL_W]),
    .take      (take)
  );

  always_comb begin
    in_idle   = (state == S_IDLE);
    start_ret = in_idle && reti_req;
    start_irq = in_idle && !reti_req && take;
    sp_dec    = start_irq || (state == S_PUSH_PC);
    sp_inc    = start_ret || (state == S_POP_PS);
    vec_addr  = ADDR_W'(VEC_BASE) + ADDR_W'(vec_hold) * ADDR_W'(WORD_BYTES);
    ps_entry  = ps_hold;
    ps_entry[IL_LSB +: LVL_W] = lvl_hold;
    busy      = !in_idle;
  end

  irq_sp_reg #(.ADDR_W(ADDR_W), .SP_INIT(SP_INIT), .STEP(WORD_BYTES)) u_sp (
    .clk   (clk),
    .rst   (rst),
    .dec   (sp_dec),
    .inc   (sp_inc),
    .sp    (sp),
    .sp_dn (sp_dn)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      pc_load   <= 1'b0;
      pc_value  <= '0;
      ps_load   <= 1'b0;
      ps_value  <= '0;
      wake      <= 1'b0;
      ps_hold   <= '0;
      lvl_hold  <= '0;
      vec_hold  <= '0;
    end else begin
      mem_req <= 1'b0;
      mem_we  <= 1'b0;
      pc_load <= 1'b0;
      ps_load <= 1'b0;
      wake    <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (start_ret) begin
            mem_req  <= 1'b1;
            mem_addr <= sp;
            state    <= S_POP_PS;
          end else if (start_irq) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= sp_dn;
            mem_wdata <= eff_pc;
            ps_hold   <= eff_ps;
            lvl_hold  <= irq_level;
            vec_hold  <= irq_vector;
            wake      <= 1'b1;
            state     <= S_PUSH_PC;
          end
        end
        S_PUSH_PC: begin
          mem_req   <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= sp_dn;
          mem_wdata <= ps_hold;
          state     <= S_PUSH_PS;
        end
        S_PUSH_PS: begin
          mem_req  <= 1'b1;
          mem_addr <= vec_addr;
          state    <= S_FETCH_VEC;
        end
        S_FETCH_VEC: state <= S_JUMP;
        S_JUMP: begin
          pc_load  <= 1'b1;
          pc_value <= mem_rdata;
          ps_load  <= 1'b1;
          ps_value <= ps_entry;
          state    <= S_IDLE;
        end
        S_POP_PS: begin
          mem_req  <= 1'b1;
          mem_addr <= sp;
          state    <= S_POP_PC;
        end
        S_POP_PC: begin
          ps_hold <= mem_rdata;
          state   <= S_RESTORE;
        end
        S_RESTORE: begin
          pc_load  <= 1'b1;
          pc_value <= mem_rdata;
          ps_load  <= 1'b1;
          ps_value <= ps_hold;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] VEC_BASE = 16'h0040
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              wake,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              pc_load,
  input logic              ps_load
);
  logic rst_d = 1'b0;
  always_ff @(posedge clk) rst_d <= rst;

  always @(posedge clk) begin
    if (rst_d) begin
      assert_reset_quiet_R1: assert (!busy && !mem_req && !pc_load && !ps_load && !wake)
        else $error("R1: outputs active during reset");
    end
  end

  assert_push_pair_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && !$past(mem_we)) |=>
      (mem_req && mem_we && mem_addr == $past(mem_addr) - ADDR_W'(2)));

  assert_vec_read_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we && $past(mem_we)) |->
      (mem_addr >= ADDR_W'(VEC_BASE) && !mem_addr[0]));

  assert_load_after_busy_R5: assert property (@(posedge clk) disable iff (rst)
    pc_load |-> (ps_load && !busy && $past(busy)));

  assert_wake_once_R6: assert property (@(posedge clk) disable iff (rst)
    wake |=> !wake);

  assert_wake_from_idle_R7: assert property (@(posedge clk) disable iff (rst)
    wake |-> (busy && !$past(busy)));
endmodule

bind irq_entry_seq irq_entry_seq_chk #(.ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .wake(wake), .mem_req(mem_req),
  .mem_we(mem_we), .mem_addr(mem_addr), .pc_load(pc_load), .ps_load(ps_load)
);

// File: tb/test_irq_entry_seq.sv
`timescale 1ns/1ps
module test_irq_entry_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        irq_valid = 1'b0;
  logic [1:0]  irq_level = 2'd3;
  logic [2:0]  irq_vector = 3'd0;
  logic        reti_req = 1'b0;
  logic [15:0] cpu_pc = 16'h0000, cpu_ps = 16'h0000;
  logic        mem_req, mem_we, pc_load, ps_load, busy, wake;
  logic [15:0] mem_addr, mem_wdata, pc_value, ps_value;
  logic [15:0] mem_rdata = 16'h0000;
  logic        set_en = 1'b0;
  logic [15:0] set_pc = 16'h0, set_ps = 16'h0;
  logic [15:0] ram [0:255];
  int          errors = 0, checks = 0;
  logic [15:0] tsp = 16'h0200;

  typedef struct {
    int          kind;  // 0 write, 1 read, 2 load
    logic [15:0] a;
    logic [15:0] d;
    logic        w;
    string       req;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  irq_entry_seq i_irq_entry_seq (
    .clk(clk), .rst(rst), .irq_valid(irq_valid), .irq_level(irq_level),
    .irq_vector(irq_vector), .reti_req(reti_req), .cur_pc(cpu_pc), .cur_ps(cpu_ps),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .pc_load(pc_load), .pc_value(pc_value),
    .ps_load(ps_load), .ps_value(ps_value), .busy(busy), .wake(wake)
  );

  // synchronous memory, read data one cycle later
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) ram[mem_addr[8:1]] <= mem_wdata;
      mem_rdata <= ram[mem_addr[8:1]];
    end
  end

  // CPU model: applies loads one edge late
  always @(posedge clk) begin
    if (pc_load) cpu_pc <= pc_value;
    else if (set_en) cpu_pc <= set_pc;
    if (ps_load) cpu_ps <= ps_value;
    else if (set_en) cpu_ps <= set_ps;
  end

  function automatic logic [15:0] handler(input int v);
    return 16'h8000 + 16'(v) * 16'h0100;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic push_exp(input int k, input logic [15:0] a, input logic [15:0] d,
                          input logic w, input string req);
    exp_t e;
    e.kind = k; e.a = a; e.d = d; e.w = w; e.req = req;
    sb.push_back(e);
  endtask

  // driver side: predicted traffic of one entry
  task automatic expect_entry(input logic [15:0] pc, input logic [15:0] ps,
                              input int vec, input logic [1:0] lvl);
    logic [15:0] nps;
    nps = ps;
    nps[5:4] = lvl;
    push_exp(0, tsp - 16'd2, pc, 1'b1, "R3");
    push_exp(0, tsp - 16'd4, ps, 1'b0, "R3");
    push_exp(1, 16'h0040 + 16'(vec) * 16'd2, 16'h0, 1'b0, "R4");
    push_exp(2, handler(vec), nps, 1'b0, "R5");
    tsp = tsp - 16'd4;
  endtask

  task automatic expect_return(input logic [15:0] pc, input logic [15:0] ps);
    push_exp(1, tsp, 16'h0, 1'b0, "R8");
    push_exp(1, tsp + 16'd2, 16'h0, 1'b0, "R8");
    push_exp(2, pc, ps, 1'b0, "R8");
    tsp = tsp + 16'd4;
  endtask

  task automatic observe(input int k, input logic [15:0] a, input logic [15:0] d);
    exp_t e;
    if (sb.size() == 0) begin
      check(1'b0, "R2", $sformatf("unexpected event kind %0d", k), a, 16'h0);
      return;
    end
    e = sb.pop_front();
    check(e.kind == k, e.req, "event kind", 16'(k), 16'(e.kind));
    check(e.a == a, e.req, (k == 2) ? "loaded pc" : "address", a, e.a);
    if (k != 1) check(e.d == d, e.req, (k == 2) ? "loaded ps" : "write data", d, e.d);
    if (k == 0) check(wake == e.w, "R6", "wake with write", 16'(wake), 16'(e.w));
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_req) observe(mem_we ? 0 : 1, mem_addr, mem_we ? mem_wdata : 16'h0);
      if (pc_load || ps_load) begin
        check(pc_load && ps_load, "R5", "loads paired", {15'd0, ps_load}, 16'd1);
        observe(2, pc_value, ps_value);
      end
      if (wake && !(mem_req && mem_we)) check(1'b0, "R6", "stray wake", 16'd1, 16'd0);
    end
  end

  task automatic set_cpu(input logic [15:0] pc, input logic [15:0] ps);
    @(negedge clk);
    set_en = 1'b1; set_pc = pc; set_ps = ps;
    @(negedge clk);
    set_en = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) ram[i] = 16'h0000;
    for (int v = 0; v < 8; v++) ram[32 + v] = handler(v);
    repeat (5) @(negedge clk);
    // R1: reset state
    check(!busy, "R1", "busy", 16'(busy), 16'd0);
    check(!mem_req, "R1", "mem_req", 16'(mem_req), 16'd0);
    check(!pc_load && !ps_load, "R1", "loads", 16'(pc_load), 16'd0);
    check(!wake, "R1", "wake", 16'(wake), 16'd0);
    rst = 1'b0;

    // R2: enable bit clear blocks a top-priority request
    set_cpu(16'h1234, 16'h0031);
    irq_valid = 1'b1; irq_level = 2'd0; irq_vector = 3'd2;
    repeat (4) @(negedge clk);
    check(!busy, "R2", "busy with I=0", 16'(busy), 16'd0);
    irq_valid = 1'b0;

    // R2: equal and lower priority rejected
    set_cpu(16'h1234, 16'h0061);
    irq_valid = 1'b1; irq_level = 2'd2;
    repeat (3) @(negedge clk);
    check(!busy, "R2", "busy with equal level", 16'(busy), 16'd0);
    irq_level = 2'd3;
    repeat (3) @(negedge clk);
    check(!busy, "R2", "busy with lower level", 16'(busy), 16'd0);
    irq_valid = 1'b0;
    @(negedge clk);

    // R2..R6: accepted entry at level 1; R7: level 0 waits, then nests
    expect_entry(16'h1234, 16'h0061, 3, 2'd1);
    expect_entry(handler(3), 16'h0051, 5, 2'd0);
    irq_valid = 1'b1; irq_level = 2'd1; irq_vector = 3'd3;
    @(negedge clk);
    check(busy, "R7", "busy after accept", 16'(busy), 16'd1);
    irq_level = 2'd0; irq_vector = 3'd5;
    @(negedge clk);
    check(busy, "R7", "busy mid entry", 16'(busy), 16'd1);
    wait_idle();
    wait_idle();
    check(cpu_ps == 16'h0041, "R7", "ps after nest", cpu_ps, 16'h0041);
    check(!busy, "R7", "no retake at own level", 16'(busy), 16'd0);
    irq_valid = 1'b0;
    @(negedge clk);

    // R8: two nested returns, last frame first
    expect_return(handler(3), 16'h0051);
    reti_req = 1'b1; @(negedge clk); reti_req = 1'b0;
    wait_idle();
    expect_return(16'h1234, 16'h0061);
    reti_req = 1'b1; @(negedge clk); reti_req = 1'b0;
    wait_idle();
    check(cpu_pc == 16'h1234, "R8", "pc after returns", cpu_pc, 16'h1234);

    // R1/R8: stack pointer back at its start; return wins a tie
    expect_entry(16'h1234, 16'h0061, 1, 2'd0);
    irq_valid = 1'b1; irq_level = 2'd0; irq_vector = 3'd1;
    @(negedge clk);
    irq_valid = 1'b0;
    wait_idle();
    expect_return(16'h1234, 16'h0061);
    reti_req = 1'b1; irq_valid = 1'b1; irq_level = 2'd0; irq_vector = 3'd4;
    @(negedge clk);
    reti_req = 1'b0; irq_valid = 1'b0;
    wait_idle();

    check(sb.size() == 0, "R8", "pending expected events", 16'(sb.size()), 16'd0);
    summary();
    $finish;
  end
endmodule